// File: doc/BRIEF.md
# Sequential Four-Round ARX Permutation Engine

This block evaluates a fixed four-round add-rotate-XOR permutation on a 64-bit state, held as two 32-bit words, using a single 32-bit arithmetic unit over twelve clock cycles. A 32-bit round constant is supplied with the operands. The block trades throughput for area: one ripple-carry adder serves both modular addition and XOR. In XOR mode the adder's carry chain is gated to zero. A small per-bit rotation multiplexer sits in front of the adder's second operand.

A user presents the two state words and the constant, then pulses `start` while the engine is idle. The engine raises `busy` and performs one step per cycle. A one-cycle `done` pulse then marks the moment `x_out` and `y_out` carry the result. The result stays on the outputs until the next accepted start.

Each round performs three steps in a fixed order. First, the left word gains the right word rotated right by the round's first amount, as a modular addition. Second, the right word is XORed with the new left word rotated right by the round's second amount. Third, the left word is XORed with the constant. The rotation pairs per round are (31, 24), (17, 17), (0, 31) and (24, 16).

Top module: `arx_seq_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `x_out` and `y_out` read 0.
- R2: For any inputs (x, y, c), the outputs at `done` equal the four-round permutation. Each round, in order from round 0 to round 3, does: x = x + rotr(y, r); y = y ^ rotr(x, s); x = x ^ c. The (r, s) pairs are (31,24), (17,17), (0,31), (24,16). rotr is a right rotation on 32 bits.
- R3: If `start` is sampled high at rising edge k while idle, `done` is high for exactly one cycle, the cycle after edge k+12.
- R4: `busy` is high in the cycles after edges k through k+11, is low while `done` is high, and never rises without an accepted start.
- R5: A `start` pulse, or a change of `x_in`, `y_in` or `c_in`, while `busy` is high has no effect on the result or on the timing of `done`.
- R6: While idle and without `start`, `x_out` and `y_out` hold their last values.
- R7: The addition is modulo 2^32: the carry out of bit 31 is dropped. XOR steps propagate no carry between bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new evaluation; accepted only when idle |
| x_in | input | 32 | Left input word |
| y_in | input | 32 | Right input word |
| c_in | input | 32 | Round constant |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: outputs hold the result |
| x_out | output | 32 | Left word of the state |
| y_out | output | 32 | Right word of the state |

## Verification
The hardest condition to reach is a step where carries must either ripple across the whole word or be fully suppressed. A random vector rarely makes a long carry chain coincide with an XOR step. The stimulus therefore includes all-ones and alternating-pattern words with chosen constants. These force full-length carry runs in the addition steps. Any carry leaking into an XOR step would then corrupt many bits of the comparison. A second scenario feeds a new start and fresh operands in the middle of a run. It checks that neither the latched operands nor the cycle count move.

// File: rtl/arx_seq_core.sv
module arx_seq_core #(
  parameter int W     = 32,
  parameter int STEPS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] c_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out
);
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  localparam logic [2:0] ROT0  = 3'd0;
  localparam logic [2:0] ROT16 = 3'd1;
  localparam logic [2:0] ROT17 = 3'd2;
  localparam logic [2:0] ROT24 = 3'd3;
  localparam logic [2:0] ROT31 = 3'd4;

  localparam logic [1:0] OP_ADD  = 2'd0;
  localparam logic [1:0] OP_MIXY = 2'd1;
  localparam logic [1:0] OP_KEY  = 2'd2;

  logic [W-1:0]  xr, yr, cr;
  logic [CW-1:0] step;
  logic          run, fin;

  logic [1:0]    op;
  logic [2:0]    rsel;
  logic [W-1:0]  opa, opb, opb_rot, sum;
  logic [W-1:0]  cy;
  logic          xmode;

  always_comb begin
    op   = OP_ADD;
    rsel = ROT0;
    case (step)
      4'd0:  begin op = OP_ADD;  rsel = ROT31; end
      4'd1:  begin op = OP_MIXY; rsel = ROT24; end
      4'd2:  begin op = OP_KEY;  rsel = ROT0;  end
      4'd3:  begin op = OP_ADD;  rsel = ROT17; end
      4'd4:  begin op = OP_MIXY; rsel = ROT17; end
      4'd5:  begin op = OP_KEY;  rsel = ROT0;  end
      4'd6:  begin op = OP_ADD;  rsel = ROT0;  end
      4'd7:  begin op = OP_MIXY; rsel = ROT31; end
      4'd8:  begin op = OP_KEY;  rsel = ROT0;  end
      4'd9:  begin op = OP_ADD;  rsel = ROT24; end
      4'd10: begin op = OP_MIXY; rsel = ROT16; end
      4'd11: begin op = OP_KEY;  rsel = ROT0;  end
      default: begin op = OP_KEY; rsel = ROT0; end
    endcase
  end

  assign xmode = (op != OP_ADD);
  assign opa   = (op == OP_MIXY) ? yr : xr;
  assign opb   = (op == OP_ADD) ? yr : (op == OP_MIXY) ? xr : cr;

  for (genvar i = 0; i < W; i++) begin : g_rot
    always_comb begin
      case (rsel)
        ROT16:   opb_rot[i] = opb[(i + 16) % W];
        ROT17:   opb_rot[i] = opb[(i + 17) % W];
        ROT24:   opb_rot[i] = opb[(i + 24) % W];
        ROT31:   opb_rot[i] = opb[(i + 31) % W];
        default: opb_rot[i] = opb[i];
      endcase
    end
  end

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = opa[i] ^ opb_rot[i] ^ cy[i];
    if (i < W - 1) begin : g_c
      assign cy[i+1] = ((opa[i] & opb_rot[i]) | (cy[i] & (opa[i] ^ opb_rot[i]))) & ~xmode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr   <= '0;
      yr   <= '0;
      cr   <= '0;
      step <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!run) begin
        if (start) begin
          xr   <= x_in;
          yr   <= y_in;
          cr   <= c_in;
          step <= '0;
          run  <= 1'b1;
        end
      end else begin
        if (op == OP_MIXY) yr <= sum;
        else               xr <= sum;
        if (step == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  assign busy  = run;
  assign done  = fin;
  assign x_out = xr;
  assign y_out = yr;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == LAST) |=> (done && !busy));
  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != LAST) |=> busy);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));
  assert_xor_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op != OP_ADD) |-> (sum == (opa ^ opb_rot)));
endmodule

// File: tb/arx_seq_core_tb.sv
module arx_seq_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] x_in = '0, y_in = '0, c_in = '0;
  logic        busy, done;
  logic [31:0] x_out, y_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  arx_seq_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .c_in(c_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out)
  );

  function automatic logic [31:0] rr(input logic [31:0] v, input int k);
    if (k == 0) return v;
    return (v >> k) | (v << (32 - k));
  endfunction

  function automatic logic [63:0] model(input logic [31:0] x0, input logic [31:0] y0,
                                        input logic [31:0] c);
    int ra [4] = '{31, 17, 0, 24};
    int sa [4] = '{24, 17, 31, 16};
    logic [31:0] x, y;
    x = x0; y = y0;
    for (int r = 0; r < 4; r++) begin
      x = x + rr(y, ra[r]);
      y = y ^ rr(x, sa[r]);
      x = x ^ c;
    end
    return {x, y};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one evaluation; optionally disturbs inputs mid-run (R5).
  task automatic run_vec(input logic [31:0] x, input logic [31:0] y, input logic [31:0] c,
                         input bit disturb, input string req);
    logic [63:0] exp;
    int n;
    exp = model(x, y, c);
    @(negedge clk);
    x_in = x; y_in = y; c_in = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R4 busy after start", {62'd0, busy, done}, 64'd2);
    n = 0;
    while (!done && n < 40) begin
      if (disturb && n == 5) begin
        start = 1'b1; x_in = ~x; y_in = x ^ 32'h5a5a_a5a5; c_in = ~c;
      end
      if (disturb && n == 6) start = 1'b0;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!done && n < 12)
        check(busy, "R4 busy during run", {63'd0, busy}, 64'd1);
    end
    start = 1'b0;
    check(n == 12, disturb ? "R5 timing" : "R3 cycles to done", 64'(n), 64'd12);
    check({x_out, y_out} == exp, req, {x_out, y_out}, exp);
    check(!busy, "R4 busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(!done, "R3 done single pulse", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    check(!busy && !done && x_out == 0 && y_out == 0, "R1 reset state",
          {30'd0, busy, done, x_out ^ y_out}, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    keep = {x_out, y_out};
    x_in = 32'h1234_5678; y_in = 32'h9abc_def0; c_in = 32'hffff_0000;
    repeat (5) @(negedge clk);
    check({x_out, y_out} == keep, "R6 outputs hold while idle", {x_out, y_out}, keep);
    check(!busy, "R6 stays idle without start", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #10000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_vec(32'h0, 32'h0, 32'h0, 1'b0, "R2 zero vector");
    run_vec(32'h0123_4567, 32'h89ab_cdef, 32'hb7e1_5162, 1'b0, "R2 vector a");
    run_vec(32'hdead_beef, 32'h0bad_f00d, 32'hbf71_5880, 1'b0, "R2 vector b");
    run_vec(32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 1'b0, "R7 all ones carries");
    run_vec(32'h5555_5555, 32'haaaa_aaaa, 32'h0000_0001, 1'b0, "R7 alternating bits");
    run_vec(32'hffff_fffe, 32'h0000_0003, 32'h8000_0000, 1'b0, "R7 wrap modulo");
    t_hold();
    run_vec(32'h3243_f6a8, 32'h885a_308d, 32'h38b4_da56, 1'b1, "R5 mid-run start ignored");
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      run_vec(a, b, c, 1'b0, "R2 random vector");
    end
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule